// File: doc/BRIEF.md
# Camera capture controller

This block sits between a host command port and a camera peripheral. The host issues one command per cycle. A command carries an opcode and an argument. Three motion commands move the camera's pan, tilt and zoom axes by signed steps. Each axis stays inside fixed bounds. Other commands do the following:

- turn the camera on and off
- load the destination address and the frame count for a capture
- mask or unmask the interrupt
- launch a capture

While a capture runs, every pixel word from the sensor side becomes one DMA write beat. The beats go to consecutive addresses. Frames are fixed-length bursts of `FRAME_WORDS` words. The frame count falls by one after each full burst. When it reaches zero the capture ends with a done status.

Turning the camera off during a capture aborts the capture at once. Status bits record completion, abort, an axis bound being hit and a rejected launch. The interrupt output is the OR of these status bits, gated by the interrupt enable.

Top module: `cam_ctrl`

## Requirements
- R1: After reset the following hold: all three axis positions are 0, the camera is off, busy is low, dma_valid is low, status is 0 and irq is low.
- R2: A command with cmd_op 1 (pan) or 2 (tilt) adds the two's-complement value in the low ANG_W bits of cmd_arg to that axis position. The new position is visible on the next cycle.
- R3: The pan position is held within ±PAN_LIM and the tilt position within ±TILT_LIM. A step that would pass a bound clamps the position to that bound and sets status bit 2 (range error).
- R4: cmd_op 3 (zoom) adds a signed step to the zoom position. The result is clamped to the range 0..ZOOM_MAX, and a clamp sets status bit 2.
- R5: cmd_op 4 turns the camera on and cmd_op 5 turns it off, as shown on cam_on.
- R6: cmd_op 10 (launch) is accepted only when all three of these hold: the camera is on, the frame count is nonzero and the block is idle. An accepted launch raises busy and clears status to 0. The launch uses the address set by cmd_op 6 and the frame count set by cmd_op 7, both taken from cmd_arg.
- R7: While busy, each cycle with pix_valid produces, one cycle later, a dma_valid beat. The beat carries that pixel word, and its address starts at the loaded address and increments by one per beat.
- R8: After N×FRAME_WORDS beats, busy falls and status bit 0 (done) is set, both in the same cycle as the last beat appears.
- R9: A launch that is not accepted sets status bit 3 (start error) and leaves busy unchanged.
- R10: cmd_op 5 while busy clears busy, sets status bit 1 (aborted) and suppresses any further DMA beats. A pixel offered in the same cycle as the abort is discarded.
- R11: pix_valid while not busy produces no DMA beat.
- R12: irq is high exactly when the interrupt is enabled and any status bit is set. cmd_op 8 enables the interrupt and cmd_op 9 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | ADDR_W | Command argument (step, address or frame count) |
| pix_valid | input | 1 | Pixel word present |
| pix_data | input | DATA_W | Pixel word |
| pan_pos | output | ANG_W | Signed pan position |
| tilt_pos | output | ANG_W | Signed tilt position |
| zoom_pos | output | ANG_W | Zoom position |
| cam_on | output | 1 | Camera running |
| busy | output | 1 | Capture in progress |
| dma_valid | output | 1 | DMA write beat |
| dma_addr | output | ADDR_W | DMA write address |
| dma_data | output | DATA_W | DMA write data |
| status | output | 4 | {start error, range error, aborted, done} |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an abort in the middle of a frame. To get there, the camera must be on, the address and a multi-frame count must be loaded, a launch must be accepted, and only part of a burst must be fed before the stop arrives.

The bench scripts that sequence directly. After the stop it offers one more pixel and confirms that no beat appears. It also checks the frame-boundary decrement by feeding two complete frames, with idle gaps, and sampling busy and done right after the seventh and eighth beats.

// File: rtl/cam_ctrl_pkg.sv
package cam_ctrl_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_PAN        = 4'd1,
        OP_TILT       = 4'd2,
        OP_ZOOM       = 4'd3,
        OP_CAM_ON     = 4'd4,
        OP_CAM_OFF    = 4'd5,
        OP_SET_ADDR   = 4'd6,
        OP_SET_FRAMES = 4'd7,
        OP_IRQ_ON     = 4'd8,
        OP_IRQ_OFF    = 4'd9,
        OP_LAUNCH     = 4'd10
    } cam_op_e;

    typedef struct packed {
        logic err_start;
        logic err_range;
        logic aborted;
        logic done;
    } cam_status_t;

endpackage

// File: rtl/cam_axis.sv
module cam_axis #(
    parameter int W    = 8,
    parameter int MINV = -90,
    parameter int MAXV = 90
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_valid,
    input  logic signed [W-1:0] step,
    output logic signed [W-1:0] pos,
    output logic                clamped
);
    localparam logic signed [W:0] LO = (W+1)'(MINV);
    localparam logic signed [W:0] HI = (W+1)'(MAXV);

    logic signed [W-1:0] pos_d, pos_q;
    logic signed [W:0]   sum;

    always_comb begin
        sum     = {pos_q[W-1], pos_q} + {step[W-1], step};
        pos_d   = pos_q;
        clamped = 1'b0;
        if (step_valid) begin
            if (sum > HI) begin
                pos_d   = HI[W-1:0];
                clamped = 1'b1;
            end else if (sum < LO) begin
                pos_d   = LO[W-1:0];
                clamped = 1'b1;
            end else begin
                pos_d = sum[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/cam_burst.sv
module cam_burst #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int FCNT_W      = 8,
    parameter int FRAME_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [FCNT_W-1:0] load_frames,
    input  logic              abort,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              busy,
    output logic              finish,
    output logic              dma_valid,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [DATA_W-1:0] dma_data
);
    localparam int WIDX_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(FRAME_WORDS - 1);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] ptr;
        logic [FCNT_W-1:0] left;
        logic [WIDX_W-1:0] widx;
        logic              dv;
        logic [ADDR_W-1:0] da;
        logic [DATA_W-1:0] dd;
    } burst_t;

    burst_t d, q;
    logic   take, last_word;

    always_comb begin
        take      = q.busy && pix_valid && !abort;
        last_word = (q.widx == LAST_W);
        finish    = take && last_word && (q.left == FCNT_W'(1));
        d         = q;
        d.dv      = 1'b0;
        if (load) begin
            d.busy = 1'b1;
            d.ptr  = load_addr;
            d.left = load_frames;
            d.widx = '0;
        end else if (abort) begin
            d.busy = 1'b0;
        end else if (take) begin
            d.dv  = 1'b1;
            d.da  = q.ptr;
            d.dd  = pix_data;
            d.ptr = q.ptr + 1'b1;
            if (last_word) begin
                d.widx = '0;
                d.left = q.left - 1'b1;
                if (q.left == FCNT_W'(1)) d.busy = 1'b0;
            end else begin
                d.widx = q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign dma_valid = q.dv;
    assign dma_addr  = q.da;
    assign dma_data  = q.dd;
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
    import cam_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int ANG_W       = 8,
    parameter int FCNT_W      = 8,
    parameter int FRAME_WORDS = 4,
    parameter int PAN_LIM     = 90,
    parameter int TILT_LIM    = 45,
    parameter int ZOOM_MAX    = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [3:0]              cmd_op,
    input  logic [ADDR_W-1:0]       cmd_arg,
    input  logic                    pix_valid,
    input  logic [DATA_W-1:0]       pix_data,
    output logic signed [ANG_W-1:0] pan_pos,
    output logic signed [ANG_W-1:0] tilt_pos,
    output logic signed [ANG_W-1:0] zoom_pos,
    output logic                    cam_on,
    output logic                    busy,
    output logic                    dma_valid,
    output logic [ADDR_W-1:0]       dma_addr,
    output logic [DATA_W-1:0]       dma_data,
    output logic [3:0]              status,
    output logic                    irq
);
    localparam int NAX = 3;
    localparam int AX_MIN [NAX] = '{-PAN_LIM, -TILT_LIM, 0};
    localparam int AX_MAX [NAX] = '{PAN_LIM, TILT_LIM, ZOOM_MAX};
    localparam cam_op_e AX_OP [NAX] = '{OP_PAN, OP_TILT, OP_ZOOM};

    typedef struct packed {
        logic              cam_on;
        logic              irq_en;
        logic [ADDR_W-1:0] buf_addr;
        logic [FCNT_W-1:0] nframes;
        cam_status_t       st;
    } ctrl_t;

    ctrl_t   d, q;
    cam_op_e op;
    logic    go_cmd, go_ok, abort, finish;
    logic    [NAX-1:0] ax_clamp;
    logic signed [ANG_W-1:0] ax_pos [NAX];
    logic signed [ANG_W-1:0] step;

    assign op   = cam_op_e'(cmd_op);
    assign step = cmd_arg[ANG_W-1:0];

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        cam_axis #(
            .W   (ANG_W),
            .MINV(AX_MIN[g]),
            .MAXV(AX_MAX[g])
        ) u_axis (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_valid(cmd_valid && (op == AX_OP[g])),
            .step      (step),
            .pos       (ax_pos[g]),
            .clamped   (ax_clamp[g])
        );
    end

    always_comb begin
        go_cmd = cmd_valid && (op == OP_LAUNCH);
        go_ok  = go_cmd && q.cam_on && (q.nframes != '0) && !busy;
        abort  = cmd_valid && (op == OP_CAM_OFF) && busy;
        d      = q;
        if (cmd_valid) begin
            case (op)
                OP_CAM_ON:     d.cam_on   = 1'b1;
                OP_CAM_OFF:    d.cam_on   = 1'b0;
                OP_SET_ADDR:   d.buf_addr = cmd_arg;
                OP_SET_FRAMES: d.nframes  = cmd_arg[FCNT_W-1:0];
                OP_IRQ_ON:     d.irq_en   = 1'b1;
                OP_IRQ_OFF:    d.irq_en   = 1'b0;
                default: ;
            endcase
        end
        if (|ax_clamp)        d.st.err_range = 1'b1;
        if (go_ok)            d.st           = '0;
        if (go_cmd && !go_ok) d.st.err_start = 1'b1;
        if (finish)           d.st.done      = 1'b1;
        if (abort)            d.st.aborted   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    cam_burst #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FCNT_W     (FCNT_W),
        .FRAME_WORDS(FRAME_WORDS)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (go_ok),
        .load_addr  (q.buf_addr),
        .load_frames(q.nframes),
        .abort      (abort),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .busy       (busy),
        .finish     (finish),
        .dma_valid  (dma_valid),
        .dma_addr   (dma_addr),
        .dma_data   (dma_data)
    );

    assign pan_pos  = ax_pos[0];
    assign tilt_pos = ax_pos[1];
    assign zoom_pos = ax_pos[2];
    assign cam_on   = q.cam_on;
    assign status   = q.st;
    assign irq      = q.irq_en && (|q.st);
endmodule

// File: rtl/cam_ctrl_chk.sv
module cam_ctrl_chk #(
    parameter int ANG_W    = 8,
    parameter int PAN_LIM  = 90,
    parameter int TILT_LIM = 45
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [3:0]              cmd_op,
    input logic                    pix_valid,
    input logic                    cam_on,
    input logic                    busy,
    input logic                    dma_valid,
    input logic signed [ANG_W-1:0] pan_pos,
    input logic signed [ANG_W-1:0] tilt_pos,
    input logic [3:0]              status,
    input logic                    irq
);
    // R3
    pan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pan_pos) <= PAN_LIM) && (int'(pan_pos) >= -PAN_LIM));

    // R3
    tilt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tilt_pos) <= TILT_LIM) && (int'(tilt_pos) >= -TILT_LIM));

    // R10
    abort_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && cmd_op == 4'd5) |=> (!busy && status[1] && !dma_valid));

    // R11
    idle_pixel_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pix_valid) |=> !dma_valid);

    // R9
    launch_off_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cam_on && cmd_valid && cmd_op == 4'd10) |=> (!busy && status[3]));

    // R12
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 4'd0));
endmodule

bind cam_ctrl cam_ctrl_chk #(
    .ANG_W   (ANG_W),
    .PAN_LIM (PAN_LIM),
    .TILT_LIM(TILT_LIM)
) u_cam_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .pix_valid(pix_valid),
    .cam_on   (cam_on),
    .busy     (busy),
    .dma_valid(dma_valid),
    .pan_pos  (pan_pos),
    .tilt_pos (tilt_pos),
    .status   (status),
    .irq      (irq)
);

// File: tb/test_cam_ctrl.sv
`timescale 1ns/1ps
module test_cam_ctrl;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int ANG_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_arg = '0;
    logic              pix_valid = 1'b0;
    logic [DATA_W-1:0] pix_data = '0;
    logic signed [ANG_W-1:0] pan_pos, tilt_pos, zoom_pos;
    logic              cam_on, busy, dma_valid, irq;
    logic [ADDR_W-1:0] dma_addr;
    logic [DATA_W-1:0] dma_data;
    logic [3:0]        status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cam_ctrl i_cam_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .pix_valid(pix_valid), .pix_data(pix_data),
        .pan_pos(pan_pos), .tilt_pos(tilt_pos), .zoom_pos(zoom_pos),
        .cam_on(cam_on), .busy(busy), .dma_valid(dma_valid),
        .dma_addr(dma_addr), .dma_data(dma_data), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmd(input int op, input int arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_arg   = ADDR_W'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pix(input int data, input int exp_addr, input string tag);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = DATA_W'(data);
        @(negedge clk);
        pix_valid = 1'b0;
        chk(dma_valid == 1'b1, {tag, " beat"}, int'(dma_valid), 1);
        chk(dma_addr == ADDR_W'(exp_addr), {tag, " addr"}, int'(dma_addr), exp_addr);
        chk(dma_data == DATA_W'(data), {tag, " data"}, int'(dma_data), data);
    endtask

    task automatic t_reset();
        chk(pan_pos == 0 && tilt_pos == 0 && zoom_pos == 0, "R1 positions", int'(pan_pos), 0);
        chk(!cam_on && !busy && !dma_valid, "R1 flags", int'({cam_on, busy, dma_valid}), 0);
        chk(status == 4'd0 && !irq, "R1 status", int'(status), 0);
    endtask

    task automatic t_motion();
        cmd(1, 30);
        chk(pan_pos == 30, "R2 pan +30", int'(pan_pos), 30);
        cmd(1, 8'hCE);
        chk(pan_pos == -20, "R2 pan -50", int'(pan_pos), -20);
        cmd(2, 20);
        chk(tilt_pos == 20, "R2 tilt +20", int'(tilt_pos), 20);
        chk(status == 4'd0, "R2 no range error", int'(status), 0);
    endtask

    task automatic t_saturate();
        cmd(1, 127);
        chk(pan_pos == 90, "R3 pan high clamp", int'(pan_pos), 90);
        chk(status[2] == 1'b1, "R3 range bit", int'(status), 4);
        cmd(1, 8'h80);
        cmd(1, 8'h9C);
        chk(pan_pos == -90, "R3 pan low clamp", int'(pan_pos), -90);
        cmd(2, 100);
        chk(tilt_pos == 45, "R3 tilt clamp", int'(tilt_pos), 45);
    endtask

    task automatic t_zoom();
        cmd(3, 10);
        chk(zoom_pos == 10, "R4 zoom +10", int'(zoom_pos), 10);
        cmd(3, 10);
        chk(zoom_pos == 15, "R4 zoom top clamp", int'(zoom_pos), 15);
        cmd(3, 8'hEC);
        chk(zoom_pos == 0, "R4 zoom floor clamp", int'(zoom_pos), 0);
    endtask

    task automatic t_reject();
        cmd(7, 2);
        cmd(10, 0);
        chk(!busy && status[3], "R9 launch with camera off", int'({busy, status[3]}), 1);
        cmd(4, 0);
        chk(cam_on == 1'b1, "R5 camera on", int'(cam_on), 1);
        cmd(7, 0);
        cmd(10, 0);
        chk(!busy, "R9 launch with zero frames", int'(busy), 0);
        cmd(5, 0);
        chk(cam_on == 1'b0, "R5 camera off", int'(cam_on), 0);
    endtask

    task automatic t_idle_pix();
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = 16'h5555;
        @(negedge clk);
        pix_valid = 1'b0;
        chk(!dma_valid, "R11 idle pixel dropped", int'(dma_valid), 0);
    endtask

    task automatic t_capture();
        cmd(8, 0);
        cmd(4, 0);
        cmd(6, 16'h0100);
        cmd(7, 2);
        cmd(10, 0);
        chk(busy && status == 4'd0, "R6 launch accepted, status cleared", int'({busy, status}), 16);
        chk(!irq, "R12 irq low after clear", int'(irq), 0);
        cmd(10, 0);
        chk(busy && status[3], "R9 launch while busy", int'({busy, status[3]}), 3);
        for (int i = 0; i < 8; i++) begin
            pix(16'hA000 + i, 16'h0100 + i, "R7 capture");
            if (i == 6) chk(busy && !status[0], "R8 not done before last", int'({busy, status[0]}), 2);
            if (i == 2) @(negedge clk);
        end
        chk(!busy && status[0], "R8 done after two frames", int'({busy, status[0]}), 1);
        chk(irq == 1'b1, "R12 irq on done", int'(irq), 1);
        cmd(9, 0);
        chk(!irq && status[0], "R12 masked irq", int'(irq), 0);
    endtask

    task automatic t_abort();
        cmd(6, 16'h0200);
        cmd(7, 3);
        cmd(10, 0);
        pix(16'hB000, 16'h0200, "R7 abort prefix");
        pix(16'hB001, 16'h0201, "R7 abort prefix");
        cmd(8, 0);
        chk(!irq, "R12 irq low mid-capture", int'(irq), 0);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 4'd5;
        pix_valid = 1'b1;
        pix_data  = 16'hB002;
        @(negedge clk);
        cmd_valid = 1'b0;
        pix_valid = 1'b0;
        chk(!busy && status[1], "R10 abort status", int'({busy, status[1]}), 1);
        chk(!dma_valid, "R10 same-cycle pixel discarded", int'(dma_valid), 0);
        chk(irq == 1'b1, "R12 irq on abort", int'(irq), 1);
        @(negedge clk);
        pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        chk(!dma_valid, "R10 no beat after abort", int'(dma_valid), 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_motion();
        t_saturate();
        t_zoom();
        t_reject();
        t_idle_pix();
        t_capture();
        t_abort();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule